// File: doc/BRIEF.md
# Bit-Decoded Memory-Map Router

This block sits between a processor's two memory ports and the four things they can reach: a data cache, an instruction cache, a boot ROM and a small set of I/O registers. It does not compare address ranges. Each target owns one high address bit, so a single store can reach more than one target at once. A store to an address with both the data-cache bit and the instruction-cache bit set writes both caches in the same cycle, which keeps them coherent when code is written into memory.

The router drives one enable per target and port. Writes into the instruction cache are gated by where the processor is currently fetching from. They are allowed only while the fetch address lies in the boot ROM. Every target is a synchronous memory with one cycle of read latency. The router therefore registers which source won each read and steers that source's data back in the next cycle. A hold input freezes this registered choice while the caches stall. Addresses, write data and byte strobes go straight from the processor to the targets and do not pass through the router.

Top module: `mem_map_router`

## Requirements
- R1: A data-port read enables at most one target. Bit 31 claims the read for I/O first, then bit 30 for the ROM, then bit 28 for the data cache. The winning target's read enable is the only one asserted.
- R2: A data-port write asserts `dc_wr` whenever bit 28 is set. It asserts `ic_wr` whenever bit 29 is set and the gate in R3 allows it. For example, a store to 0x30000000 made while fetching from the ROM writes both caches in the same cycle.
- R3: `ic_wr` is asserted only while bit 30 of the current fetch address `i_addr` is set.
- R4: The ROM has no write enable. A store whose only set selection bit is bit 30 asserts no write enable at all.
- R5: The I/O word index is address bits 4:2. Indices 3 and 7 are write-only and all other indices are read-only. A read of a write-only word asserts no read enable and returns zero. A write to a read-only word asserts no `io_wr`.
- R6: Read data for a data-port read appears on `d_rdata` in the cycle after the request and comes from the source chosen in R1.
- R7: A read that selects no target, including a refused I/O read, returns zero on the following cycle. A write that selects no target asserts no enable.
- R8: On the instruction port, bit 30 selects the ROM (`rom_i_rd`) ahead of bit 28 for the instruction cache (`ic_fetch`). Other addresses select nothing. `i_rdata` follows one cycle later, and it is zero when no target was selected.
- R9: While `hold` is high, both registered read selects keep their values. Each read-data output keeps tracking the source that was latched before the hold.
- R10: After reset both registered selects point at no source, so `d_rdata` and `i_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | Cache stall; freezes the registered read selects |
| d_addr | input | 32 | Data-port byte address |
| d_rd | input | 1 | Data-port read request |
| d_wr | input | 1 | Data-port write request |
| d_rdata | output | 32 | Data-port read data, one cycle after the request |
| i_addr | input | 32 | Instruction fetch address |
| i_rd | input | 1 | Instruction fetch request |
| i_rdata | output | 32 | Fetched word, one cycle after the request |
| dc_rd | output | 1 | Data cache read enable |
| dc_wr | output | 1 | Data cache write enable |
| dc_rdata | input | 32 | Data cache read data |
| ic_fetch | output | 1 | Instruction cache read enable |
| ic_wr | output | 1 | Instruction cache write enable (from the data port) |
| ic_rdata | input | 32 | Instruction cache read data |
| rom_d_rd | output | 1 | ROM read enable, data side |
| rom_d_rdata | input | 32 | ROM read data, data side |
| rom_i_rd | output | 1 | ROM read enable, instruction side |
| rom_i_rdata | input | 32 | ROM read data, instruction side |
| io_rd | output | 1 | I/O register read enable |
| io_wr | output | 1 | I/O register write enable |
| io_rdata | input | 32 | I/O register read data |

## Verification
The bench targets the following corner cases:
- **Overlapping selection bits.** If the read priority is wrong, an I/O read whose address also has ROM or cache bits set returns ROM or cache data, and it may also pop an I/O register as a side effect.
- **Dual-target store (0x30000000).** The store is made once while fetching from the ROM and once while fetching from the cache. A missing gate lets stray instruction-cache writes through.
- **Write-only and read-only I/O words.** A broken permission check either leaks data from a transmit register or lets a write land in a status register.
- **Held cycles.** Stall cycles are mixed with reads to other targets. A select that is not frozen returns data from the wrong source while the caches stall.

// File: rtl/mmr_pkg.sv
// mmr_pkg: shared source encodings for the memory-map router.
// Assumes: value 0 of each encoding means "no source, return zero".
package mmr_pkg;

    typedef enum logic [1:0] {
        DSRC_NONE = 2'd0,
        DSRC_DC   = 2'd1,
        DSRC_ROM  = 2'd2,
        DSRC_IO   = 2'd3
    } dsrc_e;

    typedef enum logic [1:0] {
        ISRC_NONE = 2'd0,
        ISRC_IC   = 2'd1,
        ISRC_ROM  = 2'd2
    } isrc_e;

endpackage

// File: rtl/mmr_dport_decode.sv
// mmr_dport_decode: turns a data-port request into per-target enables.
// Assumes: one selection bit per target; reads resolve by fixed priority
// (I/O, ROM, data cache); writes go to every writable selected target.
module mmr_dport_decode
    import mmr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DC_BIT     = 28,
    parameter int IC_BIT     = 29,
    parameter int ROM_BIT    = 30,
    parameter int IO_BIT     = 31,
    parameter int IO_IDX_LSB = 2,
    parameter int IO_IDX_W   = 3,
    parameter logic [(1<<IO_IDX_W)-1:0] IO_WO_MASK = 8'b1000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              fetch_in_rom,
    output logic              dc_rd,
    output logic              dc_wr,
    output logic              ic_wr,
    output logic              rom_rd,
    output logic              io_rd,
    output logic              io_wr,
    output dsrc_e             src
);

    logic [IO_IDX_W-1:0] io_idx;
    logic                io_wo;

    // Pick the I/O word and look up whether it is write-only.
    always_comb begin
        io_idx = addr[IO_IDX_LSB +: IO_IDX_W];
        io_wo  = IO_WO_MASK[io_idx];
    end

    // Resolve the read source by priority; a write-only I/O word yields none.
    always_comb begin
        src = DSRC_NONE;
        if (rd) begin
            if (addr[IO_BIT])       src = io_wo ? DSRC_NONE : DSRC_IO;
            else if (addr[ROM_BIT]) src = DSRC_ROM;
            else if (addr[DC_BIT])  src = DSRC_DC;
        end
    end

    // Read enables follow the winning source only.
    always_comb begin
        dc_rd  = (src == DSRC_DC);
        rom_rd = (src == DSRC_ROM);
        io_rd  = (src == DSRC_IO);
    end

    // Write enables: every selected writable target, gated by permissions.
    always_comb begin
        dc_wr = wr && addr[DC_BIT];
        ic_wr = wr && addr[IC_BIT] && fetch_in_rom;
        io_wr = wr && addr[IO_BIT] && io_wo;
    end

    // R5: an I/O read never lands on a word that also accepts writes.
    assert_io_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && wr && addr[IO_BIT]) |-> !io_wr);

endmodule

// File: rtl/mmr_iport_decode.sv
// mmr_iport_decode: instruction-port selection (ROM ahead of I-cache).
// Assumes: the fetch region flag reflects the address, not the request.
module mmr_iport_decode
    import mmr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IC_BIT  = 28,
    parameter int ROM_BIT = 30
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    output logic              ic_fetch,
    output logic              rom_rd,
    output logic              in_rom,
    output isrc_e             src
);

    // Choose the fetch source and raise the matching enable.
    always_comb begin
        src = ISRC_NONE;
        if (rd) begin
            if (addr[ROM_BIT])     src = ISRC_ROM;
            else if (addr[IC_BIT]) src = ISRC_IC;
        end
        ic_fetch = (src == ISRC_IC);
        rom_rd   = (src == ISRC_ROM);
        in_rom   = addr[ROM_BIT];
    end

endmodule

// File: rtl/mmr_rd_return.sv
// mmr_rd_return: registers a read-source index and steers the one-cycle-late
// data of that source to the output. Index 0 returns zero.
// Assumes: sources are synchronous memories with exactly one cycle latency.
module mmr_rd_return #(
    parameter int NSRC   = 3,
    parameter int DATA_W = 32,
    localparam int SEL_W = $clog2(NSRC + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hold,
    input  logic [SEL_W-1:0]            sel_in,
    input  logic [NSRC-1:0][DATA_W-1:0] src_rdata,
    output logic [DATA_W-1:0]           rdata
);

    logic [SEL_W-1:0]            sel_q;
    logic [NSRC-1:0][DATA_W-1:0] gated;

    // Latch the source of this cycle's read unless the caches stall.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (!hold) sel_q <= sel_in;
    end

    // One AND plane per source, enabled by its index.
    for (genvar k = 0; k < NSRC; k++) begin : g_plane
        assign gated[k] = (sel_q == SEL_W'(k + 1)) ? src_rdata[k] : '0;
    end

    // OR the planes together into the returned word.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NSRC; k++) rdata = rdata | gated[k];
    end

    // R9: a stall keeps the latched source.
    assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (sel_q == $past(sel_q)));

endmodule

// File: rtl/mem_map_router.sv
// mem_map_router: bit-decoded chip selects, I-cache write gating and
// registered read-return muxing for a data port and an instruction port.
// Assumes: all targets are one-cycle synchronous memories; address, write
// data and strobes reach the targets directly, outside this block.
module mem_map_router
    import mmr_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int DC_BIT  = 28,
    parameter int IC_BIT  = 29,
    parameter int ROM_BIT = 30,
    parameter int IO_BIT  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              d_rd,
    input  logic              d_wr,
    output logic [DATA_W-1:0] d_rdata,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic              i_rd,
    output logic [DATA_W-1:0] i_rdata,
    output logic              dc_rd,
    output logic              dc_wr,
    input  logic [DATA_W-1:0] dc_rdata,
    output logic              ic_fetch,
    output logic              ic_wr,
    input  logic [DATA_W-1:0] ic_rdata,
    output logic              rom_d_rd,
    input  logic [DATA_W-1:0] rom_d_rdata,
    output logic              rom_i_rd,
    input  logic [DATA_W-1:0] rom_i_rdata,
    output logic              io_rd,
    output logic              io_wr,
    input  logic [DATA_W-1:0] io_rdata
);

    localparam int D_NSRC = 3;
    localparam int I_NSRC = 2;

    dsrc_e d_src;
    isrc_e i_src;
    logic  fetch_in_rom;

    logic [D_NSRC-1:0][DATA_W-1:0] d_srcs;
    logic [I_NSRC-1:0][DATA_W-1:0] i_srcs;

    mmr_iport_decode #(
        .ADDR_W (ADDR_W),
        .IC_BIT (DC_BIT),
        .ROM_BIT(ROM_BIT)
    ) u_idec (
        .addr    (i_addr),
        .rd      (i_rd),
        .ic_fetch(ic_fetch),
        .rom_rd  (rom_i_rd),
        .in_rom  (fetch_in_rom),
        .src     (i_src)
    );

    mmr_dport_decode #(
        .ADDR_W (ADDR_W),
        .DC_BIT (DC_BIT),
        .IC_BIT (IC_BIT),
        .ROM_BIT(ROM_BIT),
        .IO_BIT (IO_BIT)
    ) u_ddec (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (d_addr),
        .rd          (d_rd),
        .wr          (d_wr),
        .fetch_in_rom(fetch_in_rom),
        .dc_rd       (dc_rd),
        .dc_wr       (dc_wr),
        .ic_wr       (ic_wr),
        .rom_rd      (rom_d_rd),
        .io_rd       (io_rd),
        .io_wr       (io_wr),
        .src         (d_src)
    );

    // Order source data by encoding index minus one.
    always_comb begin
        d_srcs[0] = dc_rdata;
        d_srcs[1] = rom_d_rdata;
        d_srcs[2] = io_rdata;
        i_srcs[0] = ic_rdata;
        i_srcs[1] = rom_i_rdata;
    end

    mmr_rd_return #(.NSRC(D_NSRC), .DATA_W(DATA_W)) u_dret (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .sel_in   (d_src),
        .src_rdata(d_srcs),
        .rdata    (d_rdata)
    );

    mmr_rd_return #(.NSRC(I_NSRC), .DATA_W(DATA_W)) u_iret (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .sel_in   (i_src),
        .src_rdata(i_srcs),
        .rdata    (i_rdata)
    );

    // R1: a data read never enables two targets.
    assert_one_reader_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dc_rd, rom_d_rd, io_rd}));

    // R3: instruction-cache writes only while fetching from the ROM.
    assert_ic_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ic_wr |-> i_addr[ROM_BIT]);

    // R4: a ROM-only store touches nothing.
    assert_rom_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && d_addr[ROM_BIT] && !d_addr[DC_BIT] && !d_addr[IC_BIT] && !d_addr[IO_BIT])
        |-> !(dc_wr || ic_wr || io_wr));

    // R7: an unclaimed data read returns zero next cycle.
    assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rd && !hold && !dc_rd && !rom_d_rd && !io_rd) |=> (d_rdata == '0));

    // R8: the instruction port never enables both of its targets.
    assert_fetch_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ic_fetch && rom_i_rd));

endmodule

// File: tb/mem_map_router_tb_top.sv
module mem_map_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n, hold, d_rd, d_wr, i_rd;
    logic [31:0] d_addr, i_addr, d_rdata, i_rdata;
    logic [31:0] dc_rdata, ic_rdata, rom_d_rdata, rom_i_rdata, io_rdata;
    logic        dc_rd, dc_wr, ic_fetch, ic_wr, rom_d_rd, rom_i_rd, io_rd, io_wr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int exp_d  = 0;   // 0 none, 1 dc, 2 rom, 3 io
    int exp_i  = 0;   // 0 none, 1 ic, 2 rom

    always #10 clk = ~clk;

    mem_map_router dut_i (
        .clk(clk), .rst_n(rst_n), .hold(hold),
        .d_addr(d_addr), .d_rd(d_rd), .d_wr(d_wr), .d_rdata(d_rdata),
        .i_addr(i_addr), .i_rd(i_rd), .i_rdata(i_rdata),
        .dc_rd(dc_rd), .dc_wr(dc_wr), .dc_rdata(dc_rdata),
        .ic_fetch(ic_fetch), .ic_wr(ic_wr), .ic_rdata(ic_rdata),
        .rom_d_rd(rom_d_rd), .rom_d_rdata(rom_d_rdata),
        .rom_i_rd(rom_i_rd), .rom_i_rdata(rom_i_rdata),
        .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Data read source per R1/R5.
    function automatic int d_src_of(input logic [31:0] a, input logic rd);
        if (!rd)   return 0;
        if (a[31]) return (a[4:2] == 3'd3 || a[4:2] == 3'd7) ? 0 : 3;
        if (a[30]) return 2;
        if (a[28]) return 1;
        return 0;
    endfunction

    // Instruction source per R8.
    function automatic int i_src_of(input logic [31:0] a, input logic rd);
        if (!rd)   return 0;
        if (a[30]) return 2;
        if (a[28]) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] d_val(input int s);
        case (s)
            1: return dc_rdata;
            2: return rom_d_rdata;
            3: return io_rdata;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] i_val(input int s);
        case (s)
            1: return ic_rdata;
            2: return rom_i_rdata;
            default: return 32'h0;
        endcase
    endfunction

    // One cycle: drive at negedge, check enables and returned data, update model.
    task automatic step(input logic [31:0] da, input logic dr, input logic dw,
                        input logic [31:0] ia, input logic ir, input logic h);
        int ds, is_;
        logic wo;
        @(negedge clk);
        d_addr = da; d_rd = dr; d_wr = dw; i_addr = ia; i_rd = ir; hold = h;
        dc_rdata = $urandom; ic_rdata = $urandom; rom_d_rdata = $urandom;
        rom_i_rdata = $urandom; io_rdata = $urandom;
        #1;
        ds  = d_src_of(da, dr);
        is_ = i_src_of(ia, ir);
        wo  = (da[4:2] == 3'd3 || da[4:2] == 3'd7);
        check("R1 dc_rd",    {31'd0, dc_rd},    {31'd0, ds == 1});
        check("R1 rom_d_rd", {31'd0, rom_d_rd}, {31'd0, ds == 2});
        check("R5 io_rd",    {31'd0, io_rd},    {31'd0, ds == 3});
        check("R2 dc_wr",    {31'd0, dc_wr},    {31'd0, dw && da[28]});
        check("R3 ic_wr",    {31'd0, ic_wr},    {31'd0, dw && da[29] && ia[30]});
        check("R5 io_wr",    {31'd0, io_wr},    {31'd0, dw && da[31] && wo});
        check("R8 ic_fetch", {31'd0, ic_fetch}, {31'd0, is_ == 1});
        check("R8 rom_i_rd", {31'd0, rom_i_rd}, {31'd0, is_ == 2});
        check("R6 d_rdata",  d_rdata, d_val(exp_d));
        check("R8 i_rdata",  i_rdata, i_val(exp_i));
        if (!h) begin
            exp_d = ds;
            exp_i = is_;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; hold = 1'b0; d_rd = 1'b1; d_wr = 1'b0; i_rd = 1'b1;
        d_addr = 32'h1000_0000; i_addr = 32'h4000_0000;
        dc_rdata = 32'hdead_0001; ic_rdata = 32'hdead_0002; rom_d_rdata = 32'hdead_0003;
        rom_i_rdata = 32'hdead_0004; io_rdata = 32'hdead_0005;
        repeat (3) @(negedge clk);
        check("R10 d_rdata reset", d_rdata, 32'h0);
        check("R10 i_rdata reset", i_rdata, 32'h0);
        d_rd = 1'b0; i_rd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_d = 0; exp_i = 0;

        // R2/R3: dual-target store while fetching from the ROM, then from the cache.
        step(32'h3000_0000, 1'b0, 1'b1, 32'h4000_0100, 1'b1, 1'b0);
        step(32'h3000_0000, 1'b0, 1'b1, 32'h1000_0100, 1'b1, 1'b0);
        // R4: ROM-only store.
        step(32'h4000_0010, 1'b0, 1'b1, 32'h4000_0000, 1'b0, 1'b0);
        // R5: read of write-only word, write to read-only word, legal accesses.
        step(32'h8000_000C, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);
        step(32'h8000_0004, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);
        step(32'h8000_001C, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);
        step(32'h8000_0010, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0);
        // R1: overlapping bits, I/O wins then ROM wins.
        step(32'hD000_0000, 1'b1, 1'b0, 32'h5000_0000, 1'b1, 1'b0);
        step(32'h5000_0000, 1'b1, 1'b0, 32'h1000_0000, 1'b1, 1'b0);
        // R7: read hitting nothing.
        step(32'h0000_1000, 1'b1, 1'b0, 32'h0000_0040, 1'b1, 1'b0);
        // R9: latch dc, then stall across reads elsewhere.
        step(32'h1000_0020, 1'b1, 1'b0, 32'h1000_0020, 1'b1, 1'b0);
        step(32'h8000_0000, 1'b1, 1'b0, 32'h4000_0000, 1'b1, 1'b1);
        step(32'h4000_0000, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b1);
        step(32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0);

        for (int n = 0; n < 600; n++) begin
            logic [31:0] a, ia;
            logic r, w;
            a  = {4'($urandom), 23'($urandom & 32'h0000_00ff), 3'($urandom), 2'b00};
            ia = {4'($urandom), 28'($urandom & 32'h0000_0ffc)};
            r  = 1'($urandom);
            w  = ~r & 1'($urandom);
            step(a, r, w, ia, 1'($urandom), ($urandom % 5) == 0);
        end

        step(32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule